// File: doc/BRIEF.md
# Tagged-Word SPI Master Controller

This block is an SPI master that software drives through a small 32-bit register bus. Software sets the clock polarity, the clock phase, the word length and a bit-rate divisor. It then writes one word at a time into a single-entry transmit buffer. Each word carries its own tag: a 2-bit chip-select channel and an end-of-frame flag, both taken from the transmit control register at the moment the word is written.

The end-of-frame flag decides what happens to the chip select after the word. If the flag is 0, the select stays asserted so that the next word continues the same frame. If the flag is 1, the select is released. Every word sent also clocks one word in from the slave. The received word lands in a single-entry receive buffer, and the receive control register reports the tag of the word it came from.

A shift engine runs the transfer through five named states:
- ENG_IDLE: no transfer. The engine goes to ENG_SETUP when a word is waiting and both enable and master mode are set.
- ENG_SETUP: chip select is low and SCK sits at its idle level for one half period. Then the engine goes to ENG_FIRST.
- ENG_FIRST: the first half of a bit. The engine goes to ENG_SECOND.
- ENG_SECOND: the second half of a bit. The engine returns to ENG_FIRST for the next bit, or goes to ENG_HOLD after the last bit.
- ENG_HOLD: one idle half period. Then the engine goes back to ENG_IDLE, completes the word and releases the select if the word is tagged end-of-frame.

Every state lasts exactly one half period. Status flags and latched event bits feed one interrupt line through an enable mask.

Top module: `wordtag_spi_master`

## Requirements
- R1: After reset:
  - all four chip selects are high, SCK is low and the interrupt is low;
  - the event register (0x68) reads 0x08, showing only the transmit buffer empty;
  - the service register (0x44) reads 0.
- R2: A word written to the transmit buffer (0x50) is sent only while configuration (0x40) bit 31 (enable) and bit 11 (master) are both 1.
  - While either bit is 0, the word waits, nothing toggles and the transmit buffer does not read empty.
  - The configuration register reads back bits [1:0], 11, 13, 14 and 31.
- R3: SCK idles at configuration bit 14 (polarity).
  - With bit 13 (phase) at 0, MOSI is valid on the leading edge. With bit 13 at 1, MOSI is valid on the trailing edge.
  - Each word produces exactly 2N SCK edges, with N = 8 × (config[1:0] + 1) bits sent MSB first.
- R4: The bit-rate register (0x48) holds D, the half period in bus clocks; a value of 0 acts as 1.
  - The receive-full flag is set by the (1 + D·(2N+2))-th rising clock edge after the edge that wrote the transmit buffer.
- R5: The N bits sampled from MISO are placed in the receive buffer (0x58) MSB first and right-aligned. The upper bits read 0.
- R6: Transmit control (0x4C) bits [1:0] hold the channel and bit 2 holds the end-of-frame flag for the next word written. Receive control (0x54) bits [1:0] and bit 2 report the tag of the word now held in the receive buffer.
- R7: The chip select of the word's channel goes low (active low) when the word starts, and at most one select is ever low.
  - After a word with end-of-frame 0, that select stays low.
  - After a word with end-of-frame 1, all selects are high.
- R8: Event register bit 3 reads 1 while the transmit buffer is empty and bit 2 reads 1 while the receive buffer is full. Reading 0x58 clears bit 2. Service register bit 0 reads 1 while a word is in progress.
- R9: The event register latches four events:
  - bit 4: a word completed;
  - bit 5: a word arrived while the receive buffer was full (the new word replaces the old one);
  - bit 6: an end-of-frame word completed;
  - bit 7: the transmit buffer was written while full (that write is dropped).
  Writing 1 to a bit among [7:4] clears it.
- R10: The interrupt is high exactly when some event register bit in [7:2] is 1 together with the same bit of the enable register (0x6C).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects, one per channel |
| irq | output | 1 | Interrupt request |

## Verification
Register reads are combinational, so a read is sampled in the same cycle it is driven. A read side effect, such as clearing receive-full, lands on the next edge. A transmit write is taken by the engine one edge after the write, and receive-full follows D·(2N+2) edges later. The bench counts falling edges from the write edge until the interrupt, which is enabled on receive-full, rises, and compares that count with 2 + D·(2N+2) for each divisor and word length. Chip select, received data and tags are checked only after that point. A monitor on the falling clock edge counts SCK transitions and captures MOSI on the sampling edge, independently of the design.

// File: rtl/wtspi_pkg.sv
package wtspi_pkg;

    localparam int CS_NUM = 4;

    localparam logic [7:0] OFF_CFG   = 8'h40;
    localparam logic [7:0] OFF_SVC   = 8'h44;
    localparam logic [7:0] OFF_RATE  = 8'h48;
    localparam logic [7:0] OFF_TXCTL = 8'h4C;
    localparam logic [7:0] OFF_TXBUF = 8'h50;
    localparam logic [7:0] OFF_RXCTL = 8'h54;
    localparam logic [7:0] OFF_RXBUF = 8'h58;
    localparam logic [7:0] OFF_EVT   = 8'h68;
    localparam logic [7:0] OFF_IEN   = 8'h6C;

    localparam int CFG_EN_BIT   = 31;
    localparam int CFG_POL_BIT  = 14;
    localparam int CFG_PHA_BIT  = 13;
    localparam int CFG_MST_BIT  = 11;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_SETUP,
        ENG_FIRST,
        ENG_SECOND,
        ENG_HOLD
    } eng_state_t;

    typedef struct packed {
        logic       eof;
        logic [1:0] chan;
    } word_tag_t;

endpackage

// File: rtl/wtspi_rate_gen.sv
module wtspi_rate_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == half_i - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/wtspi_shift_engine.sv
module wtspi_shift_engine
    import wtspi_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [CNT_W-1:0]  nbits_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              tick_i,
    input  logic              miso_i,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] rx_o
);

    eng_state_t state_q, state_d;
    logic [WORD_W-1:0] tx_sh_q, rx_sh_q;
    logic [CNT_W-1:0]  left_q;
    logic [CNT_W-1:0]  pad;
    logic              last_bit;

    assign pad      = CNT_W'(WORD_W) - nbits_i;
    assign last_bit = (left_q == CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE:   if (start_i) state_d = ENG_SETUP;
            ENG_SETUP:  if (tick_i)  state_d = ENG_FIRST;
            ENG_FIRST:  if (tick_i)  state_d = ENG_SECOND;
            ENG_SECOND: if (tick_i)  state_d = last_bit ? ENG_HOLD : ENG_FIRST;
            ENG_HOLD:   if (tick_i)  state_d = ENG_IDLE;
            default:                 state_d = ENG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sck_o  = cpol_i;
        busy_o = 1'b1;
        done_o = 1'b0;
        unique case (state_q)
            ENG_IDLE:   busy_o = 1'b0;
            ENG_SETUP:  sck_o  = cpol_i;
            ENG_FIRST:  sck_o  = cpol_i ^ cpha_i;
            ENG_SECOND: sck_o  = cpol_i ^ ~cpha_i;
            ENG_HOLD:   done_o = tick_i;
            default:    busy_o = 1'b0;
        endcase
    end

    assign mosi_o = tx_sh_q[WORD_W-1];
    assign rx_o   = rx_sh_q;

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            left_q  <= '0;
        end else if (state_q == ENG_IDLE) begin
            if (start_i) begin
                tx_sh_q <= word_i << pad;
                rx_sh_q <= '0;
                left_q  <= nbits_i;
            end
        end else if (tick_i) begin
            if (state_q == ENG_FIRST) begin
                rx_sh_q <= {rx_sh_q[WORD_W-2:0], miso_i};
            end
            if (state_q == ENG_SECOND && !last_bit) begin
                tx_sh_q <= tx_sh_q << 1;
                left_q  <= left_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/wtspi_select_ctl.sv
module wtspi_select_ctl #(
    parameter int NUM = 4,
    parameter int CH_W = $clog2(NUM)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [CH_W-1:0] chan_i,
    input  logic            done_i,
    input  logic            eof_i,
    output logic [NUM-1:0]  cs_n_o
);

    logic            active_q;
    logic [CH_W-1:0] chan_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            chan_q   <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            chan_q   <= chan_i;
        end else if (done_i && eof_i) begin
            active_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < NUM; g++) begin : g_line
        assign cs_n_o[g] = !(active_q && (chan_q == CH_W'(g)));
    end

endmodule

// File: rtl/wordtag_spi_master.sv
module wordtag_spi_master
    import wtspi_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [CS_NUM-1:0] spi_cs_n,
    output logic              irq
);

    localparam int WORD_W = 32;
    localparam int CNT_W  = $clog2(WORD_W) + 1;

    logic [1:0]       cfg_len;
    logic             cfg_en, cfg_master, cfg_cpha, cfg_cpol;
    logic [DIV_W-1:0] rate_q, half_eff;
    word_tag_t        txctl_q, txtag_q, rxtag_q, cur_tag_q;
    logic [31:0]      txbuf_q, rxbuf_q;
    logic             tx_full_q, rx_full_q;
    logic [3:0]       evt_q, evt_set, evt_clr;
    logic [5:0]       ien_q;
    logic [7:0]       evt_view;
    logic             cur_eof;

    logic             wr_cfg, wr_rate, wr_txctl, wr_tx, wr_evt, wr_ien, rd_rx;
    logic             eng_start, eng_busy, eng_done, tick;
    logic [WORD_W-1:0] eng_rx;
    logic [CNT_W-1:0] nbits;

    assign wr_cfg   = bus_wr && (bus_addr == ADDR_W'(OFF_CFG));
    assign wr_rate  = bus_wr && (bus_addr == ADDR_W'(OFF_RATE));
    assign wr_txctl = bus_wr && (bus_addr == ADDR_W'(OFF_TXCTL));
    assign wr_tx    = bus_wr && (bus_addr == ADDR_W'(OFF_TXBUF));
    assign wr_evt   = bus_wr && (bus_addr == ADDR_W'(OFF_EVT));
    assign wr_ien   = bus_wr && (bus_addr == ADDR_W'(OFF_IEN));
    assign rd_rx    = bus_rd && (bus_addr == ADDR_W'(OFF_RXBUF));

    assign half_eff  = (rate_q == '0) ? DIV_W'(1) : rate_q;
    assign nbits     = CNT_W'({cfg_len, 3'b000}) + CNT_W'(8);
    assign eng_start = !eng_busy && tx_full_q && cfg_en && cfg_master;
    assign cur_eof   = cur_tag_q.eof;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_len    <= '0;
            cfg_en     <= 1'b0;
            cfg_master <= 1'b0;
            cfg_cpha   <= 1'b0;
            cfg_cpol   <= 1'b0;
            rate_q     <= DIV_W'(1);
            txctl_q    <= '0;
            ien_q      <= '0;
        end else begin
            if (wr_cfg) begin
                cfg_len    <= bus_wdata[1:0];
                cfg_en     <= bus_wdata[CFG_EN_BIT];
                cfg_master <= bus_wdata[CFG_MST_BIT];
                cfg_cpha   <= bus_wdata[CFG_PHA_BIT];
                cfg_cpol   <= bus_wdata[CFG_POL_BIT];
            end
            if (wr_rate)  rate_q  <= bus_wdata[DIV_W-1:0];
            if (wr_txctl) txctl_q <= bus_wdata[2:0];
            if (wr_ien)   ien_q   <= bus_wdata[7:2];
        end
    end

    // single-entry transmit buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txbuf_q   <= '0;
            txtag_q   <= '0;
            tx_full_q <= 1'b0;
            cur_tag_q <= '0;
        end else begin
            if (eng_start) begin
                tx_full_q <= 1'b0;
                cur_tag_q <= txtag_q;
            end
            if (wr_tx && !tx_full_q) begin
                txbuf_q   <= bus_wdata;
                txtag_q   <= txctl_q;
                tx_full_q <= 1'b1;
            end
        end
    end

    // single-entry receive buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxbuf_q   <= '0;
            rxtag_q   <= '0;
            rx_full_q <= 1'b0;
        end else if (eng_done) begin
            rxbuf_q   <= eng_rx;
            rxtag_q   <= cur_tag_q;
            rx_full_q <= 1'b1;
        end else if (rd_rx) begin
            rx_full_q <= 1'b0;
        end
    end

    // latched events: [0] word done, [1] overrun, [2] frame end, [3] tx overflow
    assign evt_set = {wr_tx && tx_full_q,
                      eng_done && cur_tag_q.eof,
                      eng_done && rx_full_q && !rd_rx,
                      eng_done};
    assign evt_clr = wr_evt ? bus_wdata[7:4] : 4'b0000;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= (evt_q & ~evt_clr) | evt_set;
        end
    end

    assign evt_view = {evt_q, !tx_full_q, rx_full_q, 2'b00};
    assign irq      = |(evt_view[7:2] & ien_q);

    // register read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFF_CFG): begin
                bus_rdata[1:0]         = cfg_len;
                bus_rdata[CFG_MST_BIT] = cfg_master;
                bus_rdata[CFG_PHA_BIT] = cfg_cpha;
                bus_rdata[CFG_POL_BIT] = cfg_cpol;
                bus_rdata[CFG_EN_BIT]  = cfg_en;
            end
            ADDR_W'(OFF_SVC):   bus_rdata[0]       = eng_busy;
            ADDR_W'(OFF_RATE):  bus_rdata          = 32'(rate_q);
            ADDR_W'(OFF_TXCTL): bus_rdata[2:0]     = txctl_q;
            ADDR_W'(OFF_TXBUF): bus_rdata          = txbuf_q;
            ADDR_W'(OFF_RXCTL): bus_rdata[2:0]     = rxtag_q;
            ADDR_W'(OFF_RXBUF): bus_rdata          = rxbuf_q;
            ADDR_W'(OFF_EVT):   bus_rdata[7:0]     = evt_view;
            ADDR_W'(OFF_IEN):   bus_rdata[7:2]     = ien_q;
            default:            bus_rdata          = '0;
        endcase
    end

    wtspi_rate_gen #(.DIV_W(DIV_W)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (eng_busy),
        .half_i (half_eff),
        .tick_o (tick)
    );

    wtspi_shift_engine #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (eng_start),
        .word_i  (txbuf_q),
        .nbits_i (nbits),
        .cpol_i  (cfg_cpol),
        .cpha_i  (cfg_cpha),
        .tick_i  (tick),
        .miso_i  (spi_miso),
        .sck_o   (spi_sck),
        .mosi_o  (spi_mosi),
        .busy_o  (eng_busy),
        .done_o  (eng_done),
        .rx_o    (eng_rx)
    );

    wtspi_select_ctl #(.NUM(CS_NUM)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (eng_start),
        .chan_i  (txtag_q.chan),
        .done_i  (eng_done),
        .eof_i   (cur_eof),
        .cs_n_o  (spi_cs_n)
    );

endmodule

// File: rtl/wtspi_checker.sv
module wtspi_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] cs_n,
    input logic       busy,
    input logic       start,
    input logic       done,
    input logic       eof,
    input logic       rx_full,
    input logic       wr_tx,
    input logic       tx_full,
    input logic       cfg_en,
    input logic       cfg_master
);

    p_cs_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_cs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !eof) |=> (cs_n != 4'hF));

    p_cs_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && eof) |=> (cs_n == 4'hF));

    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    p_no_start_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cfg_en && cfg_master) && !busy) |=> !busy);

    p_rx_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_full);

    p_tx_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && !tx_full) |=> tx_full);

endmodule

bind wordtag_spi_master wtspi_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (spi_cs_n),
    .busy       (eng_busy),
    .start      (eng_start),
    .done       (eng_done),
    .eof        (cur_eof),
    .rx_full    (rx_full_q),
    .wr_tx      (wr_tx),
    .tx_full    (tx_full_q),
    .cfg_en     (cfg_en),
    .cfg_master (cfg_master)
);

// File: tb/wordtag_spi_master_bench.sv
module wordtag_spi_master_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_mosi, spi_miso;
    logic [3:0]  spi_cs_n;
    logic        irq;
    logic        inv_loop = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign spi_miso = inv_loop ? ~spi_mosi : spi_mosi;

    wordtag_spi_master u_wordtag_spi_master (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n), .irq(irq)
    );

    // independent line monitor
    logic        mon_cpol = 1'b0, mon_cpha = 1'b0;
    logic        prev_sck = 1'b0;
    int          mon_edges = 0;
    logic [31:0] mon_cap = '0;
    logic [3:0]  mon_cs = 4'hF;

    always @(negedge clk) begin
        if (spi_cs_n != 4'hF && spi_sck !== prev_sck) begin
            mon_edges = mon_edges + 1;
            mon_cs = spi_cs_n;
            if ((spi_sck == ~mon_cpol) == !mon_cpha)
                mon_cap = {mon_cap[30:0], spi_mosi};
        end
        prev_sck = spi_sck;
    end

    typedef struct packed {
        logic        cpol;
        logic        cpha;
        logic [1:0]  len;
        logic [1:0]  chan;
        logic        eof;
        logic [3:0]  div;
        logic        inv;
        logic [31:0] data;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 4'd1, 1'b0, 32'h0000_00A5},
        '{1'b1, 1'b1, 2'd0, 2'd1, 1'b1, 4'd2, 1'b1, 32'h0000_003C},
        '{1'b0, 1'b1, 2'd1, 2'd2, 1'b0, 4'd1, 1'b0, 32'h0000_BEEF},
        '{1'b0, 1'b1, 2'd1, 2'd2, 1'b1, 4'd3, 1'b0, 32'h0000_1234},
        '{1'b1, 1'b0, 2'd3, 2'd3, 1'b1, 4'd0, 1'b0, 32'hDEAD_BEEF},
        '{1'b1, 1'b1, 2'd2, 2'd0, 1'b1, 4'd1, 1'b1, 32'h00C0_FFEE}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // counts falling edges from the write edge until irq (enabled on rx-full)
    task automatic wait_irq(output int k);
        k = 1;
        while (!irq && k < 4000) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(spi_cs_n == 4'hF, "R1 cs_n", 32'(spi_cs_n), 32'hF);
        check(spi_sck == 1'b0, "R1 sck", 32'(spi_sck), 0);
        check(irq == 1'b0, "R1 irq", 32'(irq), 0);
        rd(8'h68, r); check(r == 32'h08, "R1 event reg", r, 32'h08);
        rd(8'h44, r); check(r == 32'h0, "R1 service reg", r, 0);

        wr(8'h6C, 32'h04);

        // table-driven words
        foreach (VECS[i]) begin
            vec_t v = VECS[i];
            int n = 8 * (int'(v.len) + 1);
            int d = (v.div == 0) ? 1 : int'(v.div);
            logic [31:0] mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
            logic [31:0] cfgv = 32'h8000_0800 | (32'(v.cpol) << 14) | (32'(v.cpha) << 13) | 32'(v.len);
            logic [31:0] exp_rx = v.inv ? (~v.data & mask) : (v.data & mask);
            logic [3:0]  exp_cs = ~(4'b1 << v.chan);
            int e0;
            mon_cpol = v.cpol; mon_cpha = v.cpha; inv_loop = v.inv;
            wr(8'h40, cfgv);
            wr(8'h48, 32'(v.div));
            wr(8'h4C, {29'd0, v.eof, v.chan});
            e0 = mon_edges;
            wr(8'h50, v.data);
            wait_irq(k);
            check(k == 2 + d * (2 * n + 2), "R4 rx-full latency", 32'(k), 32'(2 + d * (2 * n + 2)));
            check(mon_edges - e0 == 2 * n, "R3 sck edge count", 32'(mon_edges - e0), 32'(2 * n));
            check((mon_cap & mask) == (v.data & mask), "R3 mosi on sampling edge", mon_cap & mask, v.data & mask);
            check(mon_cs == exp_cs, "R7 select during word", 32'(mon_cs), 32'(exp_cs));
            rd(8'h54, r); check(r == {29'd0, v.eof, v.chan}, "R6 rx tag", r, {29'd0, v.eof, v.chan});
            rd(8'h58, r); check(r == exp_rx, "R5 rx data", r, exp_rx);
            check(spi_cs_n == (v.eof ? 4'hF : exp_cs), "R7 select after word",
                  32'(spi_cs_n), 32'(v.eof ? 4'hF : exp_cs));
            check(spi_sck == v.cpol, "R3 sck idle level", 32'(spi_sck), 32'(v.cpol));
            if (i == 0) begin
                rd(8'h40, r); check(r == cfgv, "R2 config readback", r, cfgv);
            end
        end

        // R2 / R9: disabled, then overflowing write
        inv_loop = 1'b0; mon_cpol = 1'b0; mon_cpha = 1'b0;
        wr(8'h68, 32'hF0);
        wr(8'h40, 32'h0000_0800);
        wr(8'h48, 32'h1);
        wr(8'h4C, 32'h5);
        wr(8'h50, 32'h11);
        wr(8'h50, 32'h22);
        repeat (30) @(negedge clk);
        rd(8'h44, r); check(r == 32'h0, "R2 no transfer while disabled", r, 0);
        check(spi_cs_n == 4'hF, "R2 selects idle while disabled", 32'(spi_cs_n), 32'hF);
        rd(8'h68, r); check(r == 32'h80, "R9 overflow latched, R8 tx not empty", r, 32'h80);
        wr(8'h40, 32'h8000_0800);
        wait_irq(k);
        rd(8'h58, r); check(r == 32'h11, "R9 dropped write kept first word", r, 32'h11);
        rd(8'h68, r); check(r == 32'hD8, "R9 done/frame-end/overflow latched", r, 32'hD8);
        wr(8'h68, 32'hF0);
        rd(8'h68, r); check(r == 32'h08, "R9 write-one clear, R8 rx cleared by read", r, 32'h08);

        // R9 overrun and R10 interrupt mask
        wr(8'h6C, 32'h20);
        check(irq == 1'b0, "R10 irq low before overrun", 32'(irq), 0);
        wr(8'h50, 32'h55);
        repeat (30) @(negedge clk);
        rd(8'h44, r); check(r == 32'h1 || r == 32'h0, "R8 service reg range", r, 0);
        wr(8'h50, 32'h66);
        repeat (30) @(negedge clk);
        rd(8'h44, r); check(r == 32'h0, "R8 idle after words", r, 0);
        check(irq == 1'b1, "R10 irq on enabled overrun", 32'(irq), 1);
        rd(8'h68, r); check(r[5] == 1'b1 && r[2] == 1'b1, "R9 overrun bit", r, 32'h7C);
        rd(8'h58, r); check(r == 32'h66, "R9 newer word kept", r, 32'h66);
        wr(8'h68, 32'h20);
        check(irq == 1'b0, "R10 irq drops after clear", 32'(irq), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule